// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Sequencer

This block sits beside a CPU core and decides, at each instruction boundary or at each step of a multi-step string instruction, whether an interrupt is taken. It watches a set of peripheral sources, each with a request flag, an enable flag, a 3-bit level and a service-mode select. It also watches the CPU's global interrupt enable, its current level mask, a software-interrupt request and a return-from-interrupt request. Among the eligible sources, the one at the most urgent level is chosen.

Once a request is accepted, the block drives the CPU through entry. It asks for the dedicated registers to be pushed to the system stack and waits for that push to complete. It then presents in one cycle the new flag values and the new level mask, together with the vector to branch to. A source whose mode select is set is instead handed to an automatic transfer engine. When that transfer reports that it is finished, the block either runs the vectored entry or lets the interrupted program continue.

A return request drives a restore handshake. The context save and the context restore are each a valid/ready pair: the block raises valid and holds it, with its other outputs unchanged, until ready is seen high at a clock edge. The transfer engine is started by a level that stays high until the engine pulses its done input.

Top module: `irq_accept_seq`

## Requirements
- R1: A hardware source is eligible only when `cpu_ie`=1, its request bit=1, its enable bit=1 and `cpu_ilm` is strictly greater than its level. A source at level 7 is therefore never accepted.
- R2: Among eligible sources, the lowest level value wins. Equal levels go to the lowest source index.
- R3: An accept is reported by `acc_pulse` high for exactly one cycle, in the cycle after the edge that sampled the strobe. From that cycle until the next accept, the outputs hold:
  - `acc_src`: the winner's index;
  - `acc_vec`: VEC_BASE + index;
  - `acc_mode`: 0 (vectored), 1 (transfer) or 2 (software).
- R4: Both `cpu_bnd` and `cpu_step` cause sampling. While the block is busy with an entry, transfer or restore, strobes are ignored. Without a strobe, nothing is accepted.
- R5: Vectored entry, for mode 0:
  - `ctx_save_valid` rises in the cycle after the accept pulse and holds until `ctx_save_ready` is seen.
  - In the following cycle, `ctx_upd` is high for one cycle with `new_ie`=0, `new_sys_stk`=1, `new_ilm` equal to the winner's level, and `acc_vec` giving the vector.
- R6: A source whose `src_xfer` bit is 1 is accepted with `acc_mode`=1. `xfer_go` rises in the cycle after the accept pulse and holds until `xfer_done`. No save is requested during the transfer.
- R7: When `xfer_done` arrives with `xfer_finish`=1, the vectored entry of R5 follows, using that source's level. With `xfer_finish`=0, the block returns to idle with no save and no `ctx_upd`.
- R8: A software request at a strobe is accepted whatever the values of `cpu_ie` and `cpu_ilm`, and it beats any hardware source. It reports `acc_mode`=2 and `acc_vec`=`swi_vec`. Its entry follows R5, except that `new_ilm` keeps the mask sampled at the strobe.
- R9: A return request at a strobe, when no software request is present, raises `ctx_rest_valid` in the next cycle and holds it until `ctx_rest_ready`. It gives no accept pulse and takes precedence over hardware sources.
- R10: A hardware request still held when the block becomes idle again is accepted at the first strobe after that.
- R11: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Per-source request flags |
| src_en | input | NSRC | Per-source enable flags |
| src_lvl | input | NSRC*3 | Per-source levels, source i at bits [3i+2:3i] |
| src_xfer | input | NSRC | Per-source mode select, 1 = automatic transfer |
| cpu_ie | input | 1 | Global interrupt enable |
| cpu_ilm | input | 3 | Current level mask |
| cpu_bnd | input | 1 | Instruction-boundary strobe |
| cpu_step | input | 1 | String-step strobe |
| swi_req | input | 1 | Software interrupt request |
| swi_vec | input | VECW | Software interrupt vector number |
| reti_req | input | 1 | Return-from-interrupt request |
| acc_pulse | output | 1 | One-cycle accept indication |
| acc_src | output | log2(NSRC) | Winning source index |
| acc_vec | output | VECW | Vector number of the accepted request |
| acc_mode | output | 2 | 0 vectored, 1 transfer, 2 software |
| ctx_save_valid | output | 1 | Context save request (valid) |
| ctx_save_ready | input | 1 | Context save done (ready) |
| ctx_rest_valid | output | 1 | Context restore request (valid) |
| ctx_rest_ready | input | 1 | Context restore done (ready) |
| xfer_go | output | 1 | Transfer engine run, held until done |
| xfer_done | input | 1 | Transfer finished pulse |
| xfer_finish | input | 1 | With done: count ended or peripheral asked to stop |
| ctx_upd | output | 1 | One-cycle flag/mask update and vector load |
| new_ie | output | 1 | New global enable value |
| new_sys_stk | output | 1 | New stack select, 1 = system stack |
| new_ilm | output | 3 | New level mask |

## Verification
Some faults sit in the capture registers: a wrong winner, level or mode caught at the strobe. These show on `acc_src`, `acc_vec` and `acc_mode` one cycle after the strobe, and again as a wrong `new_ilm` when `ctx_upd` appears. Other faults sit in the sequencer state, such as a missed or extra transition. These show as `ctx_save_valid`, `xfer_go` or `ctx_rest_valid` rising in the wrong cycle or failing to hold. They also show as an accept pulse that arrives during a busy phase, or a held request that is never taken once the block is idle. The sweeps cross every level against every mask value, use mixed multi-source patterns with ties, and drive both strobe kinds. As a result, each of these faults is visible within a few cycles of the strobe that exposes it.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    MODE_VEC  = 2'd0,
    MODE_XFER = 2'd1,
    MODE_SWI  = 2'd2
  } acc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACC  = 3'd1,
    ST_SAVE = 3'd2,
    ST_LOAD = 3'd3,
    ST_XFER = 3'd4,
    ST_REST = 3'd5
  } seq_state_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 4,
  parameter int LVLW = 3,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]      req,
  input  logic [NSRC-1:0]      en,
  input  logic [NSRC*LVLW-1:0] lvl,
  input  logic                 ie,
  input  logic [LVLW-1:0]      ilm,
  output logic                 win_vld,
  output logic [IDXW-1:0]      win_idx,
  output logic [LVLW-1:0]      win_lvl
);

  logic [NSRC-1:0] elig;

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    assign elig[i] = ie & req[i] & en[i] & (ilm > lvl[i*LVLW +: LVLW]);
  end

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!win_vld || (lvl[i*LVLW +: LVLW] < win_lvl))) begin
        win_vld = 1'b1;
        win_idx = IDXW'(i);
        win_lvl = lvl[i*LVLW +: LVLW];
      end
    end
  end

  // R1
  always_comb begin
    if (win_vld) begin
      win_mask_ok_chk: assert (ie && (ilm > win_lvl));
    end
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_pkg::*;
#(
  parameter int NSRC     = 4,
  parameter int LVLW     = 3,
  parameter int VECW     = 8,
  parameter int VEC_BASE = 11,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_vld,
  input  logic [IDXW-1:0]   win_idx,
  input  logic [LVLW-1:0]   win_lvl,
  input  logic [NSRC-1:0]   src_xfer,
  input  logic [LVLW-1:0]   cpu_ilm,
  input  logic              cpu_bnd,
  input  logic              cpu_step,
  input  logic              swi_req,
  input  logic [VECW-1:0]   swi_vec,
  input  logic              reti_req,
  input  logic              ctx_save_ready,
  input  logic              ctx_rest_ready,
  input  logic              xfer_done,
  input  logic              xfer_finish,
  output logic              acc_pulse,
  output logic [IDXW-1:0]   acc_src,
  output logic [VECW-1:0]   acc_vec,
  output logic [1:0]        acc_mode,
  output logic              ctx_save_valid,
  output logic              ctx_rest_valid,
  output logic              xfer_go,
  output logic              ctx_upd,
  output logic              new_ie,
  output logic              new_sys_stk,
  output logic [LVLW-1:0]   new_ilm
);

  seq_state_e state_q;
  acc_mode_e  mode_q;
  logic [IDXW-1:0] src_q;
  logic [VECW-1:0] vec_q;
  logic [LVLW-1:0] lvl_q;
  logic            strobe;

  assign strobe = cpu_bnd | cpu_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_VEC;
      src_q   <= '0;
      vec_q   <= '0;
      lvl_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (strobe) begin
            if (swi_req) begin
              mode_q  <= MODE_SWI;
              src_q   <= '0;
              vec_q   <= swi_vec;
              lvl_q   <= cpu_ilm;
              state_q <= ST_ACC;
            end else if (reti_req) begin
              state_q <= ST_REST;
            end else if (win_vld) begin
              mode_q  <= src_xfer[win_idx] ? MODE_XFER : MODE_VEC;
              src_q   <= win_idx;
              vec_q   <= VECW'(VEC_BASE) + VECW'(win_idx);
              lvl_q   <= win_lvl;
              state_q <= ST_ACC;
            end
          end
        end
        ST_ACC:  state_q <= (mode_q == MODE_XFER) ? ST_XFER : ST_SAVE;
        ST_SAVE: if (ctx_save_ready) state_q <= ST_LOAD;
        ST_LOAD: state_q <= ST_IDLE;
        ST_XFER: if (xfer_done) state_q <= xfer_finish ? ST_SAVE : ST_IDLE;
        ST_REST: if (ctx_rest_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_pulse      = (state_q == ST_ACC);
  assign ctx_save_valid = (state_q == ST_SAVE);
  assign ctx_rest_valid = (state_q == ST_REST);
  assign xfer_go        = (state_q == ST_XFER);
  assign ctx_upd        = (state_q == ST_LOAD);
  assign new_ie         = 1'b0;
  assign new_sys_stk    = ctx_upd;
  assign new_ilm        = ctx_upd ? lvl_q : '0;
  assign acc_src        = src_q;
  assign acc_vec        = vec_q;
  assign acc_mode       = mode_q;

  // R3
  acc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |=> !acc_pulse);

  // R3
  acc_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_pulse) |-> $past(cpu_bnd || cpu_step));

  // R5
  save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_save_valid && !ctx_save_ready) |=> ctx_save_valid);

  // R5
  upd_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_upd |-> ($past(ctx_save_valid) && $past(ctx_save_ready) && !new_ie && new_sys_stk));

  // R6
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !xfer_done) |=> (xfer_go && !ctx_save_valid));

  // R9
  rest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_rest_valid && !ctx_rest_ready) |=> ctx_rest_valid);

  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_pulse, ctx_save_valid, ctx_rest_valid, xfer_go, ctx_upd}));

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
  parameter int NSRC     = 4,
  parameter int VECW     = 8,
  parameter int VEC_BASE = 11,
  localparam int LVLW = 3,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC*3-1:0] src_lvl,
  input  logic [NSRC-1:0]   src_xfer,
  input  logic              cpu_ie,
  input  logic [2:0]        cpu_ilm,
  input  logic              cpu_bnd,
  input  logic              cpu_step,
  input  logic              swi_req,
  input  logic [VECW-1:0]   swi_vec,
  input  logic              reti_req,
  output logic              acc_pulse,
  output logic [IDXW-1:0]   acc_src,
  output logic [VECW-1:0]   acc_vec,
  output logic [1:0]        acc_mode,
  output logic              ctx_save_valid,
  input  logic              ctx_save_ready,
  output logic              ctx_rest_valid,
  input  logic              ctx_rest_ready,
  output logic              xfer_go,
  input  logic              xfer_done,
  input  logic              xfer_finish,
  output logic              ctx_upd,
  output logic              new_ie,
  output logic              new_sys_stk,
  output logic [2:0]        new_ilm
);

  logic            win_vld;
  logic [IDXW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl;

  irq_pick #(.NSRC(NSRC), .LVLW(LVLW)) u_pick (
    .req     (src_req),
    .en      (src_en),
    .lvl     (src_lvl),
    .ie      (cpu_ie),
    .ilm     (cpu_ilm),
    .win_vld (win_vld),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  irq_seq_fsm #(.NSRC(NSRC), .LVLW(LVLW), .VECW(VECW), .VEC_BASE(VEC_BASE)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .win_vld        (win_vld),
    .win_idx        (win_idx),
    .win_lvl        (win_lvl),
    .src_xfer       (src_xfer),
    .cpu_ilm        (cpu_ilm),
    .cpu_bnd        (cpu_bnd),
    .cpu_step       (cpu_step),
    .swi_req        (swi_req),
    .swi_vec        (swi_vec),
    .reti_req       (reti_req),
    .ctx_save_ready (ctx_save_ready),
    .ctx_rest_ready (ctx_rest_ready),
    .xfer_done      (xfer_done),
    .xfer_finish    (xfer_finish),
    .acc_pulse      (acc_pulse),
    .acc_src        (acc_src),
    .acc_vec        (acc_vec),
    .acc_mode       (acc_mode),
    .ctx_save_valid (ctx_save_valid),
    .ctx_rest_valid (ctx_rest_valid),
    .xfer_go        (xfer_go),
    .ctx_upd        (ctx_upd),
    .new_ie         (new_ie),
    .new_sys_stk    (new_sys_stk),
    .new_ilm        (new_ilm)
  );

endmodule

// File: tb/irq_accept_seq_bench.sv
module irq_accept_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam int VBASE = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_req = '0, src_en = '0, src_xfer = '0;
  logic [NSRC*3-1:0] src_lvl = '0;
  logic cpu_ie = 1'b0, cpu_bnd = 1'b0, cpu_step = 1'b0, swi_req = 1'b0, reti_req = 1'b0;
  logic [2:0] cpu_ilm = '0;
  logic [7:0] swi_vec = '0;
  logic ctx_save_ready = 1'b0, ctx_rest_ready = 1'b0, xfer_done = 1'b0, xfer_finish = 1'b0;
  logic acc_pulse, ctx_save_valid, ctx_rest_valid, xfer_go, ctx_upd, new_ie, new_sys_stk;
  logic [1:0] acc_src, acc_mode;
  logic [7:0] acc_vec;
  logic [2:0] new_ilm;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_seq #(.NSRC(NSRC), .VECW(8), .VEC_BASE(VBASE)) u_irq_accept_seq (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en), .src_lvl(src_lvl),
    .src_xfer(src_xfer), .cpu_ie(cpu_ie), .cpu_ilm(cpu_ilm), .cpu_bnd(cpu_bnd),
    .cpu_step(cpu_step), .swi_req(swi_req), .swi_vec(swi_vec), .reti_req(reti_req),
    .acc_pulse(acc_pulse), .acc_src(acc_src), .acc_vec(acc_vec), .acc_mode(acc_mode),
    .ctx_save_valid(ctx_save_valid), .ctx_save_ready(ctx_save_ready),
    .ctx_rest_valid(ctx_rest_valid), .ctx_rest_ready(ctx_rest_ready),
    .xfer_go(xfer_go), .xfer_done(xfer_done), .xfer_finish(xfer_finish),
    .ctx_upd(ctx_upd), .new_ie(new_ie), .new_sys_stk(new_sys_stk), .new_ilm(new_ilm)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // entered at a negedge where ctx_save_valid is expected high
  task automatic run_save(input int exp_ilm, input int waits);
    chk(ctx_save_valid == 1'b1, "R5 save_valid", int'(ctx_save_valid), 1);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(ctx_save_valid && !ctx_upd, "R5 save held", int'(ctx_save_valid), 1);
    end
    ctx_save_ready = 1'b1;
    @(negedge clk);
    ctx_save_ready = 1'b0;
    chk(ctx_upd == 1'b1, "R5 upd", int'(ctx_upd), 1);
    chk(int'(new_ilm) == exp_ilm, "R5 new_ilm", int'(new_ilm), exp_ilm);
    chk(!new_ie && new_sys_stk, "R5 flags", int'({new_ie, new_sys_stk}), 1);
    @(negedge clk);
    chk(!ctx_upd && !ctx_save_valid, "R5 back idle", int'({ctx_upd, ctx_save_valid}), 0);
  endtask

  task automatic hw_trial(input bit use_step, input int waits, input bit fin);
    int best, bl, ex_mode;
    best = -1; bl = 8;
    for (int i = 0; i < NSRC; i++) begin
      int l;
      l = int'(src_lvl[i*3 +: 3]);
      if (cpu_ie && src_req[i] && src_en[i] && int'(cpu_ilm) > l && l < bl) begin
        best = i; bl = l;
      end
    end
    if (use_step) cpu_step = 1'b1; else cpu_bnd = 1'b1;
    @(negedge clk);
    cpu_step = 1'b0; cpu_bnd = 1'b0;
    chk(acc_pulse == (best >= 0), "R1/R2 accept", int'(acc_pulse), int'(best >= 0));
    if (best < 0) begin
      @(negedge clk);
      chk(!acc_pulse && !ctx_save_valid && !xfer_go, "R4 stays idle", int'(acc_pulse), 0);
      return;
    end
    ex_mode = src_xfer[best] ? 1 : 0;
    chk(int'(acc_src) == best, "R2 winner", int'(acc_src), best);
    chk(int'(acc_vec) == VBASE + best, "R3 vector", int'(acc_vec), VBASE + best);
    chk(int'(acc_mode) == ex_mode, "R6 mode", int'(acc_mode), ex_mode);
    @(negedge clk);
    chk(!acc_pulse, "R3 one cycle", int'(acc_pulse), 0);
    if (ex_mode == 0) begin
      run_save(bl, waits);
    end else begin
      chk(xfer_go && !ctx_save_valid, "R6 xfer_go", int'(xfer_go), 1);
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk(xfer_go, "R6 xfer held", int'(xfer_go), 1);
      end
      xfer_done = 1'b1; xfer_finish = fin;
      @(negedge clk);
      xfer_done = 1'b0; xfer_finish = 1'b0;
      if (fin) run_save(bl, waits);
      else chk(!xfer_go && !ctx_save_valid && !ctx_upd, "R7 resume", int'(ctx_save_valid), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk({acc_pulse, ctx_save_valid, ctx_rest_valid, xfer_go, ctx_upd, new_ie, new_sys_stk} == '0
        && acc_vec == 0 && new_ilm == 0 && acc_mode == 0, "R11 reset", int'(acc_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!acc_pulse && !ctx_save_valid, "R11 after reset", int'(acc_pulse), 0);

    // R4: no strobe, nothing accepted
    cpu_ie = 1'b1; cpu_ilm = 3'd7; src_req = 4'b0001; src_en = 4'b0001;
    repeat (3) @(negedge clk);
    chk(!acc_pulse && !ctx_save_valid, "R4 no strobe", int'(acc_pulse), 0);

    // R1: every level against every mask, single source, both strobes
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        src_req = 4'b0100; src_en = 4'b0100; src_xfer = '0;
        src_lvl = '0; src_lvl[2*3 +: 3] = 3'(l);
        cpu_ilm = 3'(m); cpu_ie = 1'b1;
        hw_trial(l[0], l % 3, 1'b0);
      end
    end

    // R1: global enable off
    cpu_ie = 1'b0; cpu_ilm = 3'd7; src_lvl = '0; src_req = '1; src_en = '1;
    hw_trial(1'b0, 0, 1'b0);

    // R2/R6/R7: mixed patterns with ties and transfer mode
    for (int t = 0; t < 400; t++) begin
      logic [31:0] r;
      r = rnd();
      src_req = r[3:0] | r[7:4];
      src_en = r[11:8] | r[15:12];
      src_lvl = rnd() [11:0];
      if (r[16]) src_lvl[5:3] = src_lvl[2:0];
      src_xfer = r[20:17];
      cpu_ilm = r[23:21];
      cpu_ie = (r[26:24] != 0);
      hw_trial(r[27], int'(r[29:28]), r[30]);
    end

    // R8: software interrupt ignores enable and mask
    src_req = '0; cpu_ie = 1'b0; cpu_ilm = 3'd0; swi_req = 1'b1; swi_vec = 8'hA5;
    cpu_bnd = 1'b1; @(negedge clk); cpu_bnd = 1'b0; swi_req = 1'b0;
    chk(acc_pulse && acc_mode == 2'd2 && acc_vec == 8'hA5, "R8 swi accept", int'(acc_vec), 165);
    @(negedge clk);
    run_save(0, 1);

    // R8: software beats an eligible hardware source, keeps mask
    cpu_ie = 1'b1; cpu_ilm = 3'd6; src_req = 4'b0001; src_en = 4'b0001; src_lvl = '0;
    src_xfer = '0; swi_req = 1'b1; swi_vec = 8'h3C;
    cpu_step = 1'b1; @(negedge clk); cpu_step = 1'b0; swi_req = 1'b0;
    chk(acc_pulse && acc_mode == 2'd2 && acc_vec == 8'h3C, "R8 swi wins", int'(acc_mode), 2);
    @(negedge clk);
    run_save(6, 0);

    // R9: return beats hardware, restore handshake
    reti_req = 1'b1; cpu_bnd = 1'b1; @(negedge clk); cpu_bnd = 1'b0; reti_req = 1'b0;
    chk(!acc_pulse && ctx_rest_valid, "R9 restore", int'(ctx_rest_valid), 1);
    @(negedge clk);
    chk(ctx_rest_valid && !acc_pulse, "R9 restore held", int'(ctx_rest_valid), 1);
    ctx_rest_ready = 1'b1; @(negedge clk); ctx_rest_ready = 1'b0;
    chk(!ctx_rest_valid && !acc_pulse, "R9 restore done", int'(ctx_rest_valid), 0);

    // R4/R10: strobes ignored while busy; held request taken afterwards
    src_req = 4'b0011; src_en = 4'b0011; src_lvl = '0;
    src_lvl[2:0] = 3'd1; src_lvl[5:3] = 3'd2; cpu_ilm = 3'd7;
    cpu_bnd = 1'b1; @(negedge clk); cpu_bnd = 1'b0;
    chk(acc_pulse && acc_src == 2'd0, "R2 first win", int'(acc_src), 0);
    @(negedge clk);
    cpu_bnd = 1'b1; @(negedge clk); cpu_bnd = 1'b0;
    chk(!acc_pulse && ctx_save_valid, "R4 busy strobe ignored", int'(acc_pulse), 0);
    run_save(1, 0);
    src_req = 4'b0010;
    @(negedge clk);
    chk(!acc_pulse, "R10 waits strobe", int'(acc_pulse), 0);
    cpu_step = 1'b1; @(negedge clk); cpu_step = 1'b0;
    chk(acc_pulse && acc_src == 2'd1 && acc_vec == 8'(VBASE + 1), "R10 pending taken", int'(acc_src), 1);
    @(negedge clk);
    run_save(2, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule